// File: doc/BRIEF.md
# Programmable Clock-Enable Divider

This block runs on a single fast base clock and produces three clock-enable strobes, one each for the CPU, bus and peripheral domains. Each strobe is high for exactly one base cycle, once every N base cycles. Logic in each domain stays on the base clock and advances only on cycles where its strobe is high.

One control word sets all three rates. Three packed 3-bit fields each select a ratio from a fixed table. One table serves the CPU and bus fields, and a second table serves the peripheral field. A PLL-enable flag multiplies every ratio by six when it is cleared.

Software writes the control word through a simple write port and can read it back at any time. Each write restarts all three dividers from phase zero, so the new rates begin cleanly.

Top module: `freq_strobe_gen`

## Requirements
- R1: After reset the control word reads 0x0E0A. The CPU strobe then fires every cycle, the bus strobe every 2 cycles and the peripheral strobe every 4 cycles.
- R2: The read port always returns the last value written, all 16 bits included, even when a field holds an out-of-spec code.
- R3: The CPU ratio comes from bits 8:6 and the bus ratio from bits 5:3. Codes 0 to 7 map to ratios 1, 2, 3, 4, 5, 8, 8, 8.
- R4: The peripheral ratio comes from bits 2:0. Codes 0 to 7 map to ratios 2, 3, 4, 6, 8, 8, 8, 8.
- R5: Bit 10 is the PLL-enable flag. When it is 0, every domain's ratio is its table value times 6.
- R6: Each strobe is high for exactly one cycle out of every N, where N is that domain's effective ratio. When N is 1, the strobe is high on every cycle.
- R7: A write restarts all three dividers. Counting the cycle after the write edge as cycle 0, each strobe is high in cycle j exactly when j mod N equals N-1. The same rule holds for cycles counted from the release of reset.
- R8: Bits 15:11 and bit 9 have no effect on any strobe rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the control word |
| wrData | input | 16 | Control word to write |
| rdData | output | 16 | Current control word |
| cpuEn | output | 1 | CPU-domain clock enable |
| busEn | output | 1 | Bus-domain clock enable |
| perEn | output | 1 | Peripheral-domain clock enable |

## Verification
A write takes effect at a single clock edge. The readback value and the new ratios are both visible in the cycle that follows, and that cycle is cycle 0 of every divider. Each strobe is derived combinationally from its counter, so a domain with ratio N first pulses in cycle N-1 after the write and then every N cycles.

Inputs are driven on falling edges. Every result is sampled on a falling edge, starting with the one right after the write edge. The expected level for cycle j is computed from j and the ratio that the requirements give. Each sampling window spans at least two full periods of the slowest domain, so the phase and the repetition are both checked.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
  localparam int NUM_DOM     = 3;
  localparam int CODE_W      = 3;
  localparam int TBL_W       = 4;
  localparam int TBL_MAX     = 8;
  localparam int PLL_OFF_DIV = 6;
  localparam int CNT_W       = $clog2(TBL_MAX * PLL_OFF_DIV + 1);

  // Field placement inside the control word (decoded by the control stage)
  localparam int CPU_LSB = 6;
  localparam int BUS_LSB = 3;
  localparam int PER_LSB = 0;
  localparam int PLL_BIT = 10;

  // Domain indices
  localparam int DOM_CPU = 0;
  localparam int DOM_BUS = 1;
  localparam int DOM_PER = 2;

  typedef struct packed {
    logic                            restart;
    logic [NUM_DOM-1:0][CNT_W-1:0]   ratio;
  } divCmd_t;

  function automatic logic [TBL_W-1:0] coreTable(input logic [CODE_W-1:0] code);
    case (code)
      3'd0:    coreTable = TBL_W'(1);
      3'd1:    coreTable = TBL_W'(2);
      3'd2:    coreTable = TBL_W'(3);
      3'd3:    coreTable = TBL_W'(4);
      3'd4:    coreTable = TBL_W'(5);
      default: coreTable = TBL_W'(8);
    endcase
  endfunction

  function automatic logic [TBL_W-1:0] perTable(input logic [CODE_W-1:0] code);
    case (code)
      3'd0:    perTable = TBL_W'(2);
      3'd1:    perTable = TBL_W'(3);
      3'd2:    perTable = TBL_W'(4);
      3'd3:    perTable = TBL_W'(6);
      default: perTable = TBL_W'(8);
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] scaleRatio(input logic [TBL_W-1:0] base,
                                                  input logic pllOn);
    logic [CNT_W-1:0] mul;
    mul = pllOn ? CNT_W'(1) : CNT_W'(PLL_OFF_DIV);
    scaleRatio = CNT_W'(base) * mul;
  endfunction
endpackage

// File: rtl/fsg_ctrl.sv
module fsg_ctrl
  import fsg_pkg::*;
#(
  parameter int               CTRL_W     = 16,
  parameter logic [CTRL_W-1:0] RESET_WORD = 16'h0E0A
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [CTRL_W-1:0] wrData,
  output logic [CTRL_W-1:0] ctrlWord,
  output divCmd_t           cmd
);
  logic                pllOn;
  logic [CODE_W-1:0]   cpuCode, busCode, perCode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     ctrlWord <= RESET_WORD;
    else if (wrEn) ctrlWord <= wrData;
  end

  assign pllOn   = ctrlWord[PLL_BIT];
  assign cpuCode = ctrlWord[CPU_LSB +: CODE_W];
  assign busCode = ctrlWord[BUS_LSB +: CODE_W];
  assign perCode = ctrlWord[PER_LSB +: CODE_W];

  always_comb begin
    cmd.restart      = wrEn;
    cmd.ratio[DOM_CPU] = scaleRatio(coreTable(cpuCode), pllOn);
    cmd.ratio[DOM_BUS] = scaleRatio(coreTable(busCode), pllOn);
    cmd.ratio[DOM_PER] = scaleRatio(perTable(perCode), pllOn);
  end

  AST_WRITE_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> ctrlWord == $past(wrData)); // R2
  AST_WORD_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(ctrlWord)); // R2
endmodule

// File: rtl/fsg_divider.sv
module fsg_divider
  import fsg_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  divCmd_t            cmd,
  output logic [NUM_DOM-1:0] strobe
);
  for (genvar g = 0; g < NUM_DOM; g++) begin : gDom
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lastCnt;

    assign lastCnt   = cmd.ratio[g] - CNT_W'(1);
    assign strobe[g] = (cnt == lastCnt);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              cnt <= '0;
      else if (cmd.restart)   cnt <= '0;
      else if (cnt >= lastCnt) cnt <= '0;
      else                    cnt <= cnt + CNT_W'(1);
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
      cnt < cmd.ratio[g]); // R6
    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rstN)
      cmd.restart |=> cnt == '0); // R7
    AST_ONE_CYCLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
      (strobe[g] && cmd.ratio[g] > CNT_W'(1) && !cmd.restart) |=> !strobe[g]); // R6
  end
endmodule

// File: rtl/freq_strobe_gen.sv
module freq_strobe_gen
  import fsg_pkg::*;
#(
  parameter int               CTRL_W     = 16,
  parameter logic [CTRL_W-1:0] RESET_WORD = 16'h0E0A
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [CTRL_W-1:0] wrData,
  output logic [CTRL_W-1:0] rdData,
  output logic              cpuEn,
  output logic              busEn,
  output logic              perEn
);
  divCmd_t             cmd;
  logic [NUM_DOM-1:0]  strobe;

  fsg_ctrl #(.CTRL_W(CTRL_W), .RESET_WORD(RESET_WORD)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .ctrlWord(rdData), .cmd(cmd)
  );

  fsg_divider u_div (
    .clk(clk), .rstN(rstN), .cmd(cmd), .strobe(strobe)
  );

  assign cpuEn = strobe[DOM_CPU];
  assign busEn = strobe[DOM_BUS];
  assign perEn = strobe[DOM_PER];
endmodule

// File: tb/freq_strobe_gen_bench.sv
module freq_strobe_gen_bench;
  logic        clk = 1'b0;
  logic        rstN, wrEn;
  logic [15:0] wrData, rdData;
  logic        cpuEn, busEn, perEn;
  int          checks = 0, fails = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  freq_strobe_gen u_freq_strobe_gen (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .cpuEn(cpuEn), .busEn(busEn), .perEn(perEn)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int coreTbl(input int c);
    case (c)
      0: return 1; 1: return 2; 2: return 3; 3: return 4; 4: return 5;
      default: return 8;
    endcase
  endfunction

  function automatic int perTbl(input int c);
    case (c)
      0: return 2; 1: return 3; 2: return 4; 3: return 6;
      default: return 8;
    endcase
  endfunction

  // Called at the falling edge of cycle 0; checks each strobe's pattern
  task automatic sampleRates(input logic [15:0] w, input string req, input int len);
    int n[3];
    int miss[3];
    int firstBad[3];
    int doubles[3];
    bit prev[3];
    int mul;
    mul = w[10] ? 1 : 6;
    n[0] = coreTbl(int'(w[8:6])) * mul;
    n[1] = coreTbl(int'(w[5:3])) * mul;
    n[2] = perTbl(int'(w[2:0])) * mul;
    for (int d = 0; d < 3; d++) begin
      miss[d] = 0; firstBad[d] = -1; doubles[d] = 0; prev[d] = 1'b0;
    end
    for (int j = 0; j < len; j++) begin
      bit got[3];
      got[0] = cpuEn; got[1] = busEn; got[2] = perEn;
      for (int d = 0; d < 3; d++) begin
        bit exp;
        exp = ((j % n[d]) == n[d] - 1);
        if (got[d] !== exp) begin
          miss[d]++;
          if (firstBad[d] < 0) firstBad[d] = j;
        end
        if (got[d] && prev[d] && n[d] > 1) doubles[d]++;
        prev[d] = got[d];
      end
      @(negedge clk);
    end
    for (int d = 0; d < 3; d++) begin
      check(miss[d] == 0, req,
            $sformatf("word=%h dom%0d ratio=%0d mismatched cycles (first at %0d)",
                      w, d, n[d], firstBad[d]), miss[d], 0);
      check(doubles[d] == 0, "R6",
            $sformatf("word=%h dom%0d back-to-back pulses", w, d), doubles[d], 0);
    end
  endtask

  // Write on one rising edge; returns at the falling edge of cycle 0
  task automatic writeWord(input logic [15:0] w);
    @(negedge clk);
    wrEn = 1'b1; wrData = w;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic writeAndWatch(input logic [15:0] w, input string req, input int len);
    writeWord(w);
    check(rdData === w, "R2", $sformatf("readback of %h", w), int'(rdData), int'(w));
    sampleRates(w, req, len);
  endtask

  task automatic testReset();
    rstN = 1'b0; wrEn = 1'b0; wrData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    check(rdData === 16'h0E0A, "R1", "reset word", int'(rdData), 16'h0E0A);
    check(cpuEn === 1'b1, "R1", "cpu strobe at cycle 0", int'(cpuEn), 1);
    @(negedge clk);
    // now at cycle 1 after reset release
    check(busEn === 1'b1 && perEn === 1'b0, "R1", "bus/per at cycle 1",
          int'({busEn, perEn}), 2);
    @(negedge clk);
    @(negedge clk);
    check(perEn === 1'b1, "R1", "per strobe at cycle 3", int'(perEn), 1);
  endtask

  task automatic testReadback();
    writeAndWatch(16'hFFFF, "R2", 24);
    writeAndWatch(16'h0000, "R2", 40);
    writeAndWatch(16'h01FF, "R2", 110);
  endtask

  task automatic testCoreSweep();
    for (int c = 0; c < 8; c++)
      writeAndWatch(16'h0400 | 16'(c << 6) | 16'((7 - c) << 3), "R3", 24);
  endtask

  task automatic testPerSweep();
    for (int c = 0; c < 8; c++)
      writeAndWatch(16'h0400 | 16'(2 << 6) | 16'(4 << 3) | 16'(c), "R4", 24);
  endtask

  task automatic testPllOff();
    writeAndWatch(16'h006B, "R5", 150);
    writeAndWatch(16'h0A0A, "R5", 80);
    writeAndWatch(16'h0FFF, "R5", 24);
  endtask

  task automatic testRestart();
    writeWord(16'h04E3);
    repeat (3) @(negedge clk);
    writeAndWatch(16'h04E3, "R7", 40);
    repeat (2) @(negedge clk);
    writeAndWatch(16'h0419, "R7", 40);
  endtask

  task automatic testIgnoredBits();
    writeAndWatch(16'hFC0A, "R8", 24);
    writeAndWatch(16'h060A, "R8", 24);
    writeAndWatch(16'hF5E3, "R8", 40);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    testReset();
    testReadback();
    testCoreSweep();
    testPerSweep();
    testPllOff();
    testRestart();
    testIgnoredBits();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule